// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This block sits next to the fetch stage of a small in-order 32-bit core and runs counted loops whose bodies contain no compare, branch or decrement instruction. Each loop has its own start address, end address and remaining-iteration register. The controller compares the current fetch address against the end address of every armed loop. When the last instruction of the body is fetched and more iterations remain, it asserts a redirect in that same cycle with the loop start as target, so the loop-back costs no bubble beyond normal sequential fetch. On the final pass it lets fetch fall through and disarms the loop.

Software arms a loop in one of two ways. A combined setup command supplies the end address and iteration count in one cycle and takes the start as the address of the instruction following the setup command. Alternatively, separate write ports load start, end and count one at a time. Two register sets support one level of nesting. Set 0 is the inner loop and wins when both sets match the same fetch address.

Top module: `hwloop_ctrl`

## Requirements
- R1: After reset every loop count is 0, and `redirect_o` stays low for any fetch address, including address 0.
- R2: A combined setup on loop `loop_sel_i` loads start = `setup_pc_i` + 4, end = `setup_end_i` and count = `setup_count_i`. The new values govern fetches from the next cycle on.
- R3: When a valid fetch address equals a loop's end address and its count is greater than 1, `redirect_o` is high in that same cycle with `redirect_target_o` equal to the loop start, and the count drops by one at the next clock edge.
- R4: When a valid fetch address equals a loop's end address and its count is 1, there is no redirect and the count becomes 0. A loop armed with count N therefore produces exactly N-1 redirects, and later fetches of its end address do not redirect.
- R5: A loop whose count is 0 never causes a redirect.
- R6: When both loops qualify for a redirect at the same fetch address, loop 0 supplies the target and only loop 0's count changes.
- R7: When loop 0 is on its last pass at an address where loop 1 qualifies, loop 1 redirects and loop 0 disarms in the same cycle.
- R8: The write ports `wr_start_en_i`, `wr_end_en_i` and `wr_count_en_i` each load a single field of loop `loop_sel_i`. A loop built only through them behaves like one armed by the combined setup.
- R9: While `fetch_valid_i` is low, `redirect_o` is low and no count changes.
- R10: A software write to a count in the same cycle as a loop-back decrement of that count takes precedence. The written value is what remains.
- R11: A valid fetch address that differs from every end address causes no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| setup_en_i | input | 1 | Combined setup command for the selected loop |
| setup_pc_i | input | 32 | Address of the setup command itself |
| setup_end_i | input | 32 | End address given by the setup command |
| setup_count_i | input | 16 | Iteration count given by the setup command |
| wr_start_en_i | input | 1 | Write `wr_addr_i` into the selected loop start |
| wr_end_en_i | input | 1 | Write `wr_addr_i` into the selected loop end |
| wr_count_en_i | input | 1 | Write `wr_count_i` into the selected loop count |
| loop_sel_i | input | 1 | Loop set addressed by setup and writes (0 inner, 1 outer) |
| wr_addr_i | input | 32 | Address data for single-field writes |
| wr_count_i | input | 16 | Count data for single-field writes |
| fetch_pc_i | input | 32 | Current fetch address |
| fetch_valid_i | input | 1 | Fetch address is valid this cycle |
| redirect_o | output | 1 | Redirect fetch this cycle |
| redirect_target_o | output | 32 | Redirect target (loop start) |

## Verification
The hardest case to reach is the cycle where both loops share one end address, loop 0 is on its last pass and loop 1 still has iterations left. This cycle shows whether priority passes correctly from the inner loop to the outer one. The stimulus reaches it by arming both sets with count 2 on the same end address and fetching that address three times. The first fetch must go to loop 0's start, the second to loop 1's start, and the third must fall through. A second hard case is a count write that lands exactly on a loop-back fetch. The bench drives the write and the matching fetch in one cycle and then checks that the following end fetch falls through.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;

    localparam int HWL_ADDR_W = 32;
    localparam int HWL_CNT_W  = 16;

    typedef struct packed {
        logic [HWL_ADDR_W-1:0] start;
        logic [HWL_ADDR_W-1:0] stop;
        logic [HWL_CNT_W-1:0]  count;
    } loop_set_t;

endpackage

// File: rtl/hwloop_match.sv
module hwloop_match
    import hwloop_pkg::*;
(
    input  logic [HWL_ADDR_W-1:0] fetch_pc_i,
    input  logic                  fetch_valid_i,
    input  loop_set_t             set_i,
    output logic                  hit_o,
    output logic                  more_o
);

    // A loop takes part only while it is armed (count not zero).
    always_comb begin
        hit_o  = fetch_valid_i && (fetch_pc_i == set_i.stop) && (set_i.count != '0);
        more_o = (set_i.count > HWL_CNT_W'(1));
    end

endmodule

// File: rtl/hwloop_prio.sv
module hwloop_prio #(
    parameter int N = 2
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] grant_o
);

    // Lowest index (innermost loop) wins.
    always_comb begin
        logic taken;
        taken   = 1'b0;
        grant_o = '0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i] && !taken) begin
                grant_o[i] = 1'b1;
                taken      = 1'b1;
            end
        end
    end

endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl
    import hwloop_pkg::*;
#(
    parameter int NUM_LOOPS   = 2,
    parameter int INSTR_BYTES = 4
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  setup_en_i,
    input  logic [HWL_ADDR_W-1:0] setup_pc_i,
    input  logic [HWL_ADDR_W-1:0] setup_end_i,
    input  logic [HWL_CNT_W-1:0]  setup_count_i,
    input  logic                  wr_start_en_i,
    input  logic                  wr_end_en_i,
    input  logic                  wr_count_en_i,
    input  logic [((NUM_LOOPS > 1) ? $clog2(NUM_LOOPS) : 1)-1:0] loop_sel_i,
    input  logic [HWL_ADDR_W-1:0] wr_addr_i,
    input  logic [HWL_CNT_W-1:0]  wr_count_i,
    input  logic [HWL_ADDR_W-1:0] fetch_pc_i,
    input  logic                  fetch_valid_i,
    output logic                  redirect_o,
    output logic [HWL_ADDR_W-1:0] redirect_target_o
);

    localparam int SEL_W = (NUM_LOOPS > 1) ? $clog2(NUM_LOOPS) : 1;

    typedef struct packed {
        loop_set_t [NUM_LOOPS-1:0] set;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_LOOPS-1:0] hit, more, req, grant;
    logic                 wr_any;

    generate
        for (genvar k = 0; k < NUM_LOOPS; k++) begin : g_match
            hwloop_match u_match (
                .fetch_pc_i   (fetch_pc_i),
                .fetch_valid_i(fetch_valid_i),
                .set_i        (st_q.set[k]),
                .hit_o        (hit[k]),
                .more_o       (more[k])
            );
            assign req[k] = hit[k] && more[k];
        end
    endgenerate

    hwloop_prio #(.N(NUM_LOOPS)) u_prio (
        .req_i  (req),
        .grant_o(grant)
    );

    assign wr_any = setup_en_i | wr_start_en_i | wr_end_en_i | wr_count_en_i;

    // Redirect is combinational from the fetch address: no bubble.
    always_comb begin
        redirect_o        = |grant;
        redirect_target_o = '0;
        for (int k = 0; k < NUM_LOOPS; k++) begin
            if (grant[k]) redirect_target_o = st_q.set[k].start;
        end
    end

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < NUM_LOOPS; k++) begin
            // Winner loops back; a loop on its last pass always disarms.
            if (hit[k] && (grant[k] || !more[k])) begin
                st_d.set[k].count = st_q.set[k].count - HWL_CNT_W'(1);
            end
        end
        if (setup_en_i) begin
            st_d.set[loop_sel_i].start = setup_pc_i + HWL_ADDR_W'(INSTR_BYTES);
            st_d.set[loop_sel_i].stop  = setup_end_i;
            st_d.set[loop_sel_i].count = setup_count_i;
        end else begin
            if (wr_start_en_i) st_d.set[loop_sel_i].start = wr_addr_i;
            if (wr_end_en_i)   st_d.set[loop_sel_i].stop  = wr_addr_i;
            if (wr_count_en_i) st_d.set[loop_sel_i].count = wr_count_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // ---------------- assertions ----------------
    assert_grant_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(grant));

    assert_valid_gates_redirect_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !fetch_valid_i |-> !redirect_o);

    assert_idle_holds_state_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!fetch_valid_i && !wr_any) |=> $stable(st_q));

    generate
        for (genvar k = 0; k < NUM_LOOPS; k++) begin : g_chk
            assert_loopback_dec_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (grant[k] && !wr_any) |=> (st_q.set[k].count == $past(st_q.set[k].count) - HWL_CNT_W'(1)));

            assert_last_pass_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (hit[k] && !more[k] && !wr_any) |=> (st_q.set[k].count == '0));

            assert_zero_never_redirect_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (st_q.set[k].count == '0) |-> !grant[k]);
        end
    endgenerate

endmodule

// File: tb/hwloop_ctrl_tb.sv
`timescale 1ns/1ps
module hwloop_ctrl_tb;
    import hwloop_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic setup_en = 1'b0, wr_start_en = 1'b0, wr_end_en = 1'b0, wr_count_en = 1'b0;
    logic [0:0] loop_sel = '0;
    logic [HWL_ADDR_W-1:0] setup_pc = '0, setup_end = '0, wr_addr = '0, fetch_pc = '0;
    logic [HWL_CNT_W-1:0]  setup_count = '0, wr_count = '0;
    logic fetch_valid = 1'b0;
    logic redirect;
    logic [HWL_ADDR_W-1:0] target;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #2 clk = ~clk;

    hwloop_ctrl u_dut (
        .clk_i(clk), .rst_ni(rst_n),
        .setup_en_i(setup_en), .setup_pc_i(setup_pc), .setup_end_i(setup_end),
        .setup_count_i(setup_count),
        .wr_start_en_i(wr_start_en), .wr_end_en_i(wr_end_en), .wr_count_en_i(wr_count_en),
        .loop_sel_i(loop_sel), .wr_addr_i(wr_addr), .wr_count_i(wr_count),
        .fetch_pc_i(fetch_pc), .fetch_valid_i(fetch_valid),
        .redirect_o(redirect), .redirect_target_o(target)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_fail++;
            $display("FAIL watchdog: act=timeout exp=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    // Present one fetch, check the same-cycle redirect, then advance a cycle.
    task automatic fetch(logic [31:0] pc, logic exp_r, logic [31:0] exp_t, string req);
        fetch_pc = pc; fetch_valid = 1'b1;
        #1;
        chk(req, {31'b0, redirect}, {31'b0, exp_r});
        if (exp_r) chk(req, target, exp_t);
        @(negedge clk);
        fetch_valid = 1'b0;
    endtask

    task automatic do_setup(logic sel, logic [31:0] pc, logic [31:0] e, logic [15:0] c);
        loop_sel = sel; setup_pc = pc; setup_end = e; setup_count = c; setup_en = 1'b1;
        @(negedge clk);
        setup_en = 1'b0;
    endtask

    task automatic t_reset();
        fetch_pc = '0; fetch_valid = 1'b1;
        #1 chk("R1 in reset", {31'b0, redirect}, 32'd0);
        fetch_valid = 1'b0;
        @(negedge clk); rst_n = 1'b1; @(negedge clk);
        fetch(32'h0, 1'b0, '0, "R1 after reset pc 0");
    endtask

    task automatic t_basic_loop();
        do_setup(1'b0, 32'h100, 32'h10C, 16'd3);
        for (int it = 0; it < 3; it++) begin
            fetch(32'h104, 1'b0, '0, "R11 body fetch");
            fetch(32'h108, 1'b0, '0, "R11 body fetch");
            if (it < 2) fetch(32'h10C, 1'b1, 32'h104, "R3/R2 loop back to setup+4");
            else        fetch(32'h10C, 1'b0, '0, "R4 last pass falls through");
        end
        fetch(32'h110, 1'b0, '0, "R11 after loop");
        fetch(32'h10C, 1'b0, '0, "R4 disarmed loop");
    endtask

    task automatic t_zero_count();
        do_setup(1'b1, 32'h500, 32'h50C, 16'd0);
        fetch(32'h50C, 1'b0, '0, "R5 zero count");
        fetch(32'h50C, 1'b0, '0, "R5 zero count again");
    endtask

    task automatic t_nested_same_end();
        do_setup(1'b0, 32'h200, 32'h20C, 16'd2);  // inner start 0x204
        do_setup(1'b1, 32'h1FC, 32'h20C, 16'd2);  // outer start 0x200
        fetch(32'h20C, 1'b1, 32'h204, "R6 inner wins");
        fetch(32'h20C, 1'b1, 32'h200, "R7 outer takes over, R6 outer untouched");
        fetch(32'h20C, 1'b0, '0, "R4 both exhausted");
    endtask

    task automatic t_single_writes();
        loop_sel = 1'b1;
        wr_addr = 32'h400; wr_start_en = 1'b1; @(negedge clk); wr_start_en = 1'b0;
        wr_addr = 32'h410; wr_end_en = 1'b1;   @(negedge clk); wr_end_en = 1'b0;
        wr_count = 16'd2;  wr_count_en = 1'b1; @(negedge clk); wr_count_en = 1'b0;
        fetch(32'h40C, 1'b0, '0, "R8 before end");
        fetch(32'h410, 1'b1, 32'h400, "R8 written loop redirects");
        fetch(32'h410, 1'b0, '0, "R8 written loop ends");
    endtask

    task automatic t_valid_gate();
        do_setup(1'b0, 32'h600, 32'h608, 16'd2);
        fetch_pc = 32'h608; fetch_valid = 1'b0;
        #1 chk("R9 invalid fetch", {31'b0, redirect}, 32'd0);
        @(negedge clk); @(negedge clk);
        fetch(32'h608, 1'b1, 32'h604, "R9 count kept while invalid");
        fetch(32'h608, 1'b0, '0, "R9 then last pass");
    endtask

    task automatic t_write_collision();
        do_setup(1'b0, 32'h300, 32'h30C, 16'd5);
        loop_sel = 1'b0; wr_count = 16'd1; wr_count_en = 1'b1;
        fetch(32'h30C, 1'b1, 32'h304, "R10 redirect in collision cycle");
        wr_count_en = 1'b0;
        fetch(32'h30C, 1'b0, '0, "R10 written count wins");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_basic_loop();
        t_zero_count();
        t_nested_same_end();
        t_single_writes();
        t_valid_gate();
        t_write_collision();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule